// File: doc/BRIEF.md
# Chained Serial-In Parallel-Out Register with Output Latch

This block collects a serial bit stream into a chain of 8-bit shift lanes and shows the result on a wide parallel bus only when it is asked to. Shifting and latching are two separate events. While a new word moves in one bit at a time, the parallel outputs keep showing the last latched word, so a load of lamps or segment drivers never sees the partial data. A parameter sets how many 8-bit lanes are chained. The last bit of the chain is brought out as a cascade output, so that several blocks can be daisy-chained from one data line.

The design runs on a single fabric clock. The two clock pins of a discrete part become two single-cycle strobes: `shift_stb` advances the shift chain and `latch_stb` copies it into the storage register. The high-impedance output state is modelled as a drive-enable output beside the value bus. A low-active clear empties the shift chain and leaves the storage register alone.

Top module: `sipo_chain`

## Requirements
- R1: While `rst` is high at a clock edge, the shift chain, `par_q`, `par_oe` and `ser_out` all become 0 after that edge.
- R2: On each edge with `shift_stb` high, every shift bit moves up one position and `ser_in` enters bit 0. Bit 7 of lane k feeds bit 0 of lane k+1, and `ser_out` is bit 7 of the last lane. A bit therefore appears on `ser_out` after 8*STAGES shifts.
- R3: On an edge with `latch_stb` high, all 8*STAGES shift bits are copied into `par_q` at once, in the same cycle.
- R4: On an edge with `latch_stb` low, `par_q` keeps its value, whatever shifting or clearing happens.
- R5: `par_oe` equals the inverse of `oe_n` one clock later. `oe_n` has no effect on `par_q` or `ser_out`.
- R6: On an edge with `clr_n` low, the shift chain (and so `ser_out`) becomes 0. `par_q` is not changed. Clear takes priority over shifting.
- R7: When `shift_stb` and `latch_stb` are high on the same edge, `par_q` takes the shift-chain contents from before that shift.
- R8: With STAGES=3, 24 bits shifted in with the most significant bit first and then latched give `par_q` equal to that 24-bit word. The first bit sent lands on `par_q[23]`.
- R9: On an edge with `shift_stb` low and `clr_n` high, the shift chain and `ser_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data, sampled when `shift_stb` is high |
| shift_stb | input | 1 | One-cycle shift event |
| latch_stb | input | 1 | One-cycle storage-load event |
| oe_n | input | 1 | Active-low output enable |
| clr_n | input | 1 | Active-low shift-chain clear, synchronous |
| par_q | output | 8*STAGES | Storage register value |
| par_oe | output | 1 | High when `par_q` is driven, low for high impedance |
| ser_out | output | 1 | Cascade output, last bit of the shift chain |

## Verification
The assertions check four things on every cycle. `par_q` holds between latch events. `par_oe` follows `oe_n` one cycle later. The cascade output changes only on a shift or a clear. The top bit of every latched word matches the cascade output from the cycle before the latch. Other behaviour needs stored history, which only the bench's scenarios can show. That covers the full 24-bit word order after a load, the pre-shift capture when shift and latch coincide, a clear that leaves the storage register intact, and the exact shift count before a bit reaches the cascade output.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int LANE_W = 8;
  typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/sipo_shift_lane.sv
module sipo_shift_lane
  import sipo_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr_n,
  input  logic  shift_en,
  input  logic  din,
  output lane_t q,
  output logic  dout
);
  // Clear outranks shift; reset outranks everything.
  always_ff @(posedge clk) begin
    if (rst || !clr_n)
      q <= '0;
    else if (shift_en)
      q <= {q[LANE_W-2:0], din};
  end

  assign dout = q[LANE_W-1];
endmodule

// File: rtl/sipo_store.sv
module sipo_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // The value in d is the one from before the current edge, so a shift on
  // the same edge cannot reach the storage register.
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (load)
      q <= d;
  end
endmodule

// File: rtl/sipo_chain.sv
module sipo_chain
  import sipo_pkg::*;
#(
  parameter int STAGES = 3,
  localparam int TOTAL = STAGES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             shift_stb,
  input  logic             latch_stb,
  input  logic             oe_n,
  input  logic             clr_n,
  output logic [TOTAL-1:0] par_q,
  output logic             par_oe,
  output logic             ser_out
);
  logic [STAGES:0]  link;
  logic [TOTAL-1:0] sr_all;

  assign link[0] = ser_in;

  for (genvar k = 0; k < STAGES; k++) begin : g_lane
    lane_t lane_q;
    sipo_shift_lane u_lane (
      .clk      (clk),
      .rst      (rst),
      .clr_n    (clr_n),
      .shift_en (shift_stb),
      .din      (link[k]),
      .q        (lane_q),
      .dout     (link[k+1])
    );
    assign sr_all[k*LANE_W +: LANE_W] = lane_q;
  end

  assign ser_out = link[STAGES];

  sipo_store #(.WIDTH(TOTAL)) u_store (
    .clk  (clk),
    .rst  (rst),
    .load (latch_stb),
    .d    (sr_all),
    .q    (par_q)
  );

  always_ff @(posedge clk) begin
    if (rst)
      par_oe <= 1'b0;
    else
      par_oe <= !oe_n;
  end
endmodule

// File: rtl/sipo_chain_chk.sv
module sipo_chain_chk #(
  parameter int TOTAL = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_stb,
  input logic             latch_stb,
  input logic             oe_n,
  input logic             clr_n,
  input logic [TOTAL-1:0] par_q,
  input logic             par_oe,
  input logic             ser_out
);
  // R1: reset empties every output
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (par_q == '0) && !par_oe && !ser_out);

  // R4: storage holds without a latch event
  a_r4_hold_no_latch: assert property (@(posedge clk) disable iff (rst)
    !latch_stb |=> $stable(par_q));

  // R5: drive enable follows oe_n one cycle later
  a_r5_oe_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (par_oe == !$past(oe_n)));

  // R9: cascade output moves only on shift or clear
  a_r9_chain_idle: assert property (@(posedge clk) disable iff (rst)
    (!shift_stb && clr_n) |=> $stable(ser_out));

  // R6: clear empties the cascade output
  a_r6_clear_chain: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> !ser_out);

  // R3 / R7: top latched bit is the pre-edge cascade bit
  a_r7_latch_top_bit: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> (par_q[TOTAL-1] == $past(ser_out)));
endmodule

bind sipo_chain sipo_chain_chk #(.TOTAL(TOTAL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .shift_stb (shift_stb),
  .latch_stb (latch_stb),
  .oe_n      (oe_n),
  .clr_n     (clr_n),
  .par_q     (par_q),
  .par_oe    (par_oe),
  .ser_out   (ser_out)
);

// File: tb/tb_sipo_chain.sv
module tb_sipo_chain;
  localparam int STAGES = 3;
  localparam int TOTAL  = STAGES * 8;

  logic clk = 1'b0;
  logic rst, ser_in, shift_stb, latch_stb, oe_n, clr_n;
  logic [TOTAL-1:0] par_q;
  logic par_oe, ser_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [TOTAL-1:0] exp_sr;
  logic [TOTAL-1:0] exp_q;

  always #2 clk = ~clk;

  sipo_chain #(.STAGES(STAGES)) dut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .shift_stb(shift_stb),
    .latch_stb(latch_stb), .oe_n(oe_n), .clr_n(clr_n),
    .par_q(par_q), .par_oe(par_oe), .ser_out(ser_out)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Caller is at a negedge; returns at the next negedge.
  task automatic cyc(input bit sh, input bit la, input bit d, input bit cl);
    shift_stb = sh; latch_stb = la; ser_in = d; clr_n = !cl;
    @(negedge clk);
    if (la) exp_q = exp_sr;
    if (cl) exp_sr = '0;
    else if (sh) exp_sr = {exp_sr[TOTAL-2:0], d};
    shift_stb = 0; latch_stb = 0; clr_n = 1;
  endtask

  task automatic t_reset();
    rst = 1; oe_n = 1; clr_n = 1; shift_stb = 0; latch_stb = 0; ser_in = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    exp_sr = '0; exp_q = '0;
    chk(par_q == '0, "R1 par_q", par_q, 0);
    chk(!par_oe, "R1 par_oe", par_oe, 0);
    chk(!ser_out, "R1 ser_out", ser_out, 0);
  endtask

  task automatic t_load24();
    logic [TOTAL-1:0] w = 24'hA5C31E;
    for (int i = TOTAL-1; i >= 0; i--) cyc(1, 0, w[i], 0);
    chk(par_q == '0, "R4 no latch yet", par_q, 0);
    chk(ser_out == w[TOTAL-1], "R2 first bit at cascade", ser_out, w[TOTAL-1]);
    cyc(0, 1, 0, 0);
    chk(par_q == w, "R8 24-bit word order", par_q, w);
    chk(par_q == exp_q, "R3 full copy", par_q, exp_q);
  endtask

  task automatic t_hold();
    logic [TOTAL-1:0] held = par_q;
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0);
    chk(par_q == held, "R4 hold while shifting", par_q, held);
    chk(ser_out == exp_sr[TOTAL-1], "R2 cascade after 5", ser_out, exp_sr[TOTAL-1]);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0);
    chk(ser_out == exp_sr[TOTAL-1], "R9 idle cascade", ser_out, exp_sr[TOTAL-1]);
    cyc(0, 1, 0, 0);
    chk(par_q == exp_sr, "R9 chain unchanged by idle", par_q, exp_sr);
  endtask

  task automatic t_same_edge();
    logic [TOTAL-1:0] pre = exp_sr;
    cyc(1, 1, 0, 0);
    chk(par_q == pre, "R7 pre-shift capture", par_q, pre);
    cyc(0, 1, 0, 0);
    chk(par_q == exp_sr, "R7 shift still applied", par_q, exp_sr);
  endtask

  task automatic t_clear();
    logic [TOTAL-1:0] held = par_q;
    cyc(1, 0, 1, 1);
    chk(par_q == held, "R6 storage kept", par_q, held);
    chk(!ser_out, "R6 cascade cleared", ser_out, 0);
    cyc(0, 1, 0, 0);
    chk(par_q == '0, "R6 chain empty", par_q, 0);
  endtask

  task automatic t_oe();
    logic [TOTAL-1:0] w = 24'h00000F;
    for (int i = TOTAL-1; i >= 0; i--) cyc(1, 0, w[i], 0);
    cyc(0, 1, 0, 0);
    oe_n = 0;
    @(negedge clk);
    chk(par_oe, "R5 enable on", par_oe, 1);
    chk(par_q == w, "R5 value unaffected", par_q, w);
    chk(ser_out == exp_sr[TOTAL-1], "R5 cascade unaffected", ser_out, exp_sr[TOTAL-1]);
    oe_n = 1;
    @(negedge clk);
    chk(!par_oe, "R5 enable off", par_oe, 0);
  endtask

  initial begin
    #(4 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load24();
    t_hold();
    t_same_edge();
    t_clear();
    t_oe();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule